// File: doc/BRIEF.md
# Serial-Load Bank Configuration Registers

This block is the write side of a cartridge bank controller. The CPU cannot write a whole configuration value at once. It feeds a 5-bit value in one bit per bus write, least significant bit first, using data bit 0 of each write into the upper 32 KB of the address space. A marker bit in a 5-bit shift register tracks the position in the sequence. When the marker reaches bit 0, the next ordinary write is the fifth one. That write commits the assembled value to one of four registers, picked by that write's address, and re-arms the shifter.

A write with data bit 7 set aborts any partial sequence. It also forces the program-bank-mode field of the control register to all ones. The block decodes the control register into a mirroring code, a program-bank mode and a pattern-bank mode. Address translation logic downstream uses these, together with the two pattern bank numbers and the program bank number.

Top module: `serial_bank_cfg`

## Requirements
- R1: On synchronous reset, the control register is 0x0C and both pattern banks and the program bank are 0. The first full sequence after reset commits on its fifth ordinary write.
- R2: A cycle with `wrEn` low, or with `cpuAddr` bit 15 clear, changes no output and does not disturb a partial sequence.
- R3: A write into the window with data bit 7 set discards any partial sequence and sets control bits 3:2 to 11. It leaves control bits 4 and 1:0 and all other registers unchanged.
- R4: Ordinary writes (bit 7 clear) supply data bit 0 as one serial bit, first write into result bit 0. The first four writes of a sequence change no register output.
- R5: The fifth write's `cpuAddr` bits 14:13 pick the destination: 00 control, 01 pattern bank 0, 10 pattern bank 1, 11 program bank. The addresses of the earlier writes in the sequence do not matter.
- R6: The program bank keeps only bits 3:0 of the committed value.
- R7: `mirrorMode` equals control bits 1:0, coded 0 single-screen lower, 1 single-screen upper, 2 vertical, 3 horizontal.
- R8: `progMode` equals control bits 3:2 and `patMode` equals control bit 4.
- R9: A commit shows on the outputs after the clock edge that samples the fifth write. The same edge re-arms the shifter, so a write in the very next cycle starts a new sequence.
- R10: Data bits 6:1 of every write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | CPU write strobe, one serial write per high cycle |
| cpuAddr | input | 16 | CPU write address |
| cpuData | input | 8 | CPU write data |
| ctrlReg | output | 5 | Control register |
| patBank0 | output | 5 | Pattern bank number 0 |
| patBank1 | output | 5 | Pattern bank number 1 |
| progBank | output | 4 | Program bank number |
| mirrorMode | output | 2 | Mirroring code |
| progMode | output | 2 | Program bank mode |
| patMode | output | 1 | Pattern bank mode |

## Verification
Two functions fall on one edge: committing the fifth bit to its register and re-arming the shifter for the next sequence. The bench provokes this by holding the strobe high for ten straight cycles, five to one address and five to another. Both registers must receive exactly their intended values, which fails if the re-arm slips by a cycle. A second case issues an abort write right after a partial sequence, and the next five-write load must land intact.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    DST_CTRL = 2'd0,
    DST_PAT0 = 2'd1,
    DST_PAT1 = 2'd2,
    DST_PROG = 2'd3
  } dest_e;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  // strobes from control to datapath, one write per cycle
  typedef struct packed {
    logic  clear;      // abort write: re-arm shifter, force mode bits
    logic  shift;      // ordinary write: take one serial bit
    logic  commit;     // this shift completes the value
    logic  serialBit;  // the bit carried by this write
    dest_e dest;       // destination if committing
  } strobe_t;

endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              shiftLsb,
  output strobe_t           strb
);

  localparam int WIN_BIT   = ADDR_W - 1;
  localparam int ABORT_BIT = DATA_W - 1;
  localparam int SEL_LO    = ADDR_W - 3;

  logic inWindow;
  logic unusedBits;

  assign inWindow   = wrEn && cpuAddr[WIN_BIT];
  assign unusedBits = ^{cpuData[ABORT_BIT-1:1], cpuAddr[SEL_LO-1:0]};

  always_comb begin
    strb           = '0;
    strb.clear     = inWindow && cpuData[ABORT_BIT];
    strb.shift     = inWindow && !cpuData[ABORT_BIT];
    strb.commit    = strb.shift && shiftLsb;
    strb.serialBit = cpuData[0];
    strb.dest      = dest_e'(cpuAddr[SEL_LO+1:SEL_LO]);
  end

  // R2: a write outside the window raises no strobe
  p_window_only_r2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !cpuAddr[WIN_BIT]) |-> !(strb.clear || strb.shift));

endmodule

// File: rtl/sbc_dpath.sv
module sbc_dpath
  import sbc_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int PROG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  output logic             shiftLsb,
  output logic [REG_W-1:0] ctrlReg,
  output logic [REG_W-1:0] patBank0,
  output logic [REG_W-1:0] patBank1,
  output logic [PROG_W-1:0] progBank,
  output logic [1:0]       mirrorMode,
  output logic [1:0]       progMode,
  output logic             patMode
);

  localparam logic [REG_W-1:0] MARKER     = REG_W'(1) << (REG_W - 1);
  localparam logic [REG_W-1:0] FORCE_MASK = REG_W'(12);
  localparam logic [REG_W-1:0] CTRL_INIT  = REG_W'(12);
  localparam int               NUM_PAT    = 2;

  logic [REG_W-1:0] shiftReg;
  logic [REG_W-1:0] newVal;
  logic [REG_W-1:0] patReg [NUM_PAT];

  assign shiftLsb = shiftReg[0];
  assign newVal   = {strb.serialBit, shiftReg[REG_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= MARKER;
    end else if (strb.clear || strb.commit) begin
      shiftReg <= MARKER;
    end else if (strb.shift) begin
      shiftReg <= newVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= CTRL_INIT;
    end else if (strb.clear) begin
      ctrlReg <= ctrlReg | FORCE_MASK;
    end else if (strb.commit && strb.dest == DST_CTRL) begin
      ctrlReg <= newVal;
    end
  end

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    localparam dest_e MY_DEST = dest_e'(g + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        patReg[g] <= '0;
      end else if (strb.commit && strb.dest == MY_DEST) begin
        patReg[g] <= newVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      progBank <= '0;
    end else if (strb.commit && strb.dest == DST_PROG) begin
      progBank <= newVal[PROG_W-1:0];
    end
  end

  assign patBank0   = patReg[0];
  assign patBank1   = patReg[1];
  assign mirrorMode = ctrlReg[1:0];
  assign progMode   = ctrlReg[3:2];
  assign patMode    = ctrlReg[4];

  // R4: the marker bit can never be lost
  p_marker_kept_r4: assert property (@(posedge clk) disable iff (rst)
    shiftReg != '0);

  // R4: a non-final serial write changes no register
  p_partial_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && !strb.commit) |=>
      ($stable(ctrlReg) && $stable(patBank0) && $stable(patBank1) && $stable(progBank)));

  // R2: without a strobe nothing moves
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(strb.shift || strb.clear) |=>
      ($stable(shiftReg) && $stable(ctrlReg) && $stable(patBank0) &&
       $stable(patBank1) && $stable(progBank)));

  // R3: abort re-arms and forces the mode field, banks untouched
  p_abort_r3: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=>
      (shiftReg == MARKER && ctrlReg[3:2] == 2'b11 && $stable(patBank0) &&
       $stable(patBank1) && $stable(progBank)));

  // R9: a commit re-arms the shifter on the same edge
  p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    strb.commit |=> shiftReg == MARKER);

endmodule

// File: rtl/serial_bank_cfg.sv
module serial_bank_cfg
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 5,
  parameter int PROG_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output logic [REG_W-1:0]  ctrlReg,
  output logic [REG_W-1:0]  patBank0,
  output logic [REG_W-1:0]  patBank1,
  output logic [PROG_W-1:0] progBank,
  output logic [1:0]        mirrorMode,
  output logic [1:0]        progMode,
  output logic              patMode
);

  strobe_t strb;
  logic    shiftLsb;

  sbc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .cpuAddr  (cpuAddr),
    .cpuData  (cpuData),
    .shiftLsb (shiftLsb),
    .strb     (strb)
  );

  sbc_dpath #(.REG_W(REG_W), .PROG_W(PROG_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .shiftLsb   (shiftLsb),
    .ctrlReg    (ctrlReg),
    .patBank0   (patBank0),
    .patBank1   (patBank1),
    .progBank   (progBank),
    .mirrorMode (mirrorMode),
    .progMode   (progMode),
    .patMode    (patMode)
  );

endmodule

// File: tb/sim_serial_bank_cfg.sv
module sim_serial_bank_cfg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic [4:0]  ctrlReg, patBank0, patBank1;
  logic [3:0]  progBank;
  logic [1:0]  mirrorMode, progMode;
  logic        patMode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  serial_bank_cfg u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .ctrlReg(ctrlReg), .patBank0(patBank0), .patBank1(patBank1),
    .progBank(progBank), .mirrorMode(mirrorMode), .progMode(progMode),
    .patMode(patMode)
  );

  localparam int NV = 8;
  localparam logic [15:0] V_ADDR [NV] = '{16'h8000, 16'hA000, 16'hC000, 16'hE000,
                                          16'h9FFF, 16'hBFFF, 16'hDFFF, 16'hFFFF};
  localparam logic [4:0]  V_VAL  [NV] = '{5'h13, 5'h15, 5'h0A, 5'h1B,
                                          5'h06, 5'h1F, 5'h00, 5'h07};
  localparam logic [4:0]  E_CTRL [NV] = '{5'h13, 5'h13, 5'h13, 5'h13,
                                          5'h06, 5'h06, 5'h06, 5'h06};
  localparam logic [4:0]  E_P0   [NV] = '{5'h00, 5'h15, 5'h15, 5'h15,
                                          5'h15, 5'h1F, 5'h1F, 5'h1F};
  localparam logic [4:0]  E_P1   [NV] = '{5'h00, 5'h00, 5'h0A, 5'h0A,
                                          5'h0A, 5'h0A, 5'h00, 5'h00};
  localparam logic [3:0]  E_PG   [NV] = '{4'h0, 4'h0, 4'h0, 4'hB,
                                          4'hB, 4'hB, 4'hB, 4'h7};

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all register outputs plus the decoded modes (R7, R8)
  task automatic chkAll(input string tag, input logic [4:0] c, input logic [4:0] p0,
                        input logic [4:0] p1, input logic [3:0] pg);
    chk({tag, " ctrl"}, ctrlReg, c);
    chk({tag, " pat0"}, patBank0, p0);
    chk({tag, " pat1"}, patBank1, p1);
    chk({tag, " prog R6"}, {1'b0, progBank}, {1'b0, pg});
    chk({tag, " mirror R7"}, {3'b0, mirrorMode}, {3'b0, c[1:0]});
    chk({tag, " progMode R8"}, {3'b0, progMode}, {3'b0, c[3:2]});
    chk({tag, " patMode R8"}, {4'b0, patMode}, {4'b0, c[4]});
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; cpuAddr = a; cpuData = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wrEn = 1'b0; cpuAddr = '0; cpuData = '0;
  endtask

  // five serial writes, bits 6:1 filled with noise (R10)
  task automatic load5(input logic [15:0] a, input logic [4:0] v, input logic [7:0] noise);
    for (int i = 0; i < 5; i++) wr(a, (noise & 8'h7E) | {7'b0, v[i]});
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chkAll("R1 reset", 5'h0C, 5'h00, 5'h00, 4'h0);

    // vector table: R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      load5(V_ADDR[v], V_VAL[v], 8'(v * 37));
      chkAll($sformatf("R5 vector %0d", v), E_CTRL[v], E_P0[v], E_P1[v], E_PG[v]);
    end

    // R4: four writes change nothing; R2 ignored cycles in between
    for (int i = 0; i < 4; i++) wr(16'hA000, 8'h01);
    idle();
    chkAll("R4 partial", 5'h06, 5'h1F, 5'h00, 4'h7);
    wr(16'h7FFF, 8'h00); wr(16'h0000, 8'h80); idle();
    @(negedge clk); cpuAddr = 16'hA000; cpuData = 8'h00;   // strobe low
    idle();
    chkAll("R2 ignored", 5'h06, 5'h1F, 5'h00, 4'h7);
    wr(16'hA000, 8'h00); idle();                            // fifth write: value 0x0F
    chk("R2 sequence intact", patBank0, 5'h0F);

    // R5: earlier addresses do not matter
    for (int i = 0; i < 4; i++) wr(16'hE000, 8'h01);
    wr(16'hC000, 8'h01); idle();
    chkAll("R5 last address", 5'h06, 5'h0F, 5'h1F, 4'h7);

    // R3: abort mid-sequence
    load5(16'h8000, 5'h11, 8'h00);
    chk("R3 setup ctrl", ctrlReg, 5'h11);
    wr(16'hC000, 8'h01); wr(16'hC000, 8'h01);
    wr(16'hD000, 8'h80); idle();
    chkAll("R3 abort", 5'h1D, 5'h0F, 5'h1F, 4'h7);
    load5(16'hC000, 5'h12, 8'h00);
    chk("R3 fresh sequence", patBank1, 5'h12);

    // R9: ten back-to-back writes, two commits
    for (int i = 0; i < 5; i++) wr(16'h8000, {7'b0, 5'h0E >> i});
    chk("R9 no early commit", ctrlReg, 5'h1D);
    for (int i = 0; i < 5; i++) wr(16'hA000, {7'b0, 5'h19 >> i});
    idle();
    chk("R9 first commit", ctrlReg, 5'h0E);
    chk("R9 second commit", patBank0, 5'h19);

    // R1: reset again mid-sequence
    wr(16'h8000, 8'h01); wr(16'h8000, 8'h01); idle();
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chkAll("R1 re-reset", 5'h0C, 5'h00, 5'h00, 4'h0);
    load5(16'hE000, 5'h15, 8'h7E);
    chk("R1 five writes after reset", {1'b0, progBank}, 5'h05);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule